// File: doc/BRIEF.md
# Overlay Permission Register Access Controller

This block owns one 64-bit configuration register built from sixteen 4-bit permission fields, and it judges every software read or write aimed at that register. For each request it weighs the requester's privilege level (0 to 3) and the access direction against a set of control inputs: which higher levels are present or enabled, coarse and fine-grained trap controls, a feature-enable bit, two flags that choose between an undefined result and a trap, and three nested-virtualisation mode bits. From these it produces exactly one outcome.

The outcome is one of five. The access can complete, with read data for reads. It can be undefined. It can trap to level 2 or to level 3, with exception class 0x18. It can be redirected to a memory slot at offset 0x2B8. Requests are accepted every cycle, and the response is registered, so it appears one clock after the request. A completed write updates the register on the same edge that registers its response. The register contents are also presented on an output, so that the translation logic can use the current permission fields.

Top module: `perm_overlay_access_ctrl`

## Requirements
- R1: While `rst` is high, on the following clock edge the register clears to all zeros and `rsp_valid` and `mem_req_valid` drop to 0.
- R2: A request with `req_valid` high produces `rsp_valid` high on the next clock edge, with `rsp_kind` encoded as 0 complete, 1 undefined, 2 trap to level 2, 3 trap to level 3, 4 redirect.
- R3: Any request from level 0 is undefined (kind 1).
- R4: At levels 1 and 2, the first check gives undefined when `el3_present`, `undef_prio` and a low `feat_en` all hold.
- R5: At level 1, the next check traps to level 2 when `el2_enabled` is set and the coarse trap bit for the direction is 1 (`trap_rd` for reads, `trap_wr` for writes).
- R6: At level 1, the next check traps to level 2 when `el2_enabled` and `fgt_present` are set, either `el3_present` is 0 or `fgt_el3_en` is 1, and the active-low fine-grained bit for the direction (`fgt_rd_n` or `fgt_wr_n`) is 0.
- R7: At levels 1 and 2, the next check applies when `el3_present` is 1 and `feat_en` is 0. The result is undefined if `undef_sel` is 1, and a trap to level 3 otherwise.
- R8: At level 1, when no earlier check fires and `nv_mode[2]` and `nv_mode[0]` are both 1, the outcome is redirect (kind 4). `mem_req_valid` is then high with `mem_req_addr` = 0x2B8, `mem_req_write` equal to the direction, and `mem_req_wdata` equal to the write data for writes.
- R9: At level 3 every access completes (kind 0). At level 2 every access completes unless R4 or R7 fires.
- R10: Both trap outcomes report `rsp_class` = 0x18. Every other outcome reports 0.
- R11: A completed write stores all 64 bits of write data, with field m in bits [4m+3:4m], and the new value is visible on `perm_value` from the response cycle. Any other outcome leaves the register unchanged.
- R12: A completed read returns the register value held at request time on `rsp_rdata`. Every other outcome returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_level | input | 2 | Privilege level of the requester |
| req_wdata | input | 64 | Write data |
| el3_present | input | 1 | Level 3 implemented |
| el2_enabled | input | 1 | Level 2 enabled for the requester |
| undef_prio | input | 1 | Undefined-priority condition |
| undef_sel | input | 1 | Undefined instead of trap to level 3 |
| feat_en | input | 1 | Feature enable from level 3 |
| trap_rd | input | 1 | Coarse read trap to level 2 |
| trap_wr | input | 1 | Coarse write trap to level 2 |
| fgt_present | input | 1 | Fine-grained trapping implemented |
| fgt_el3_en | input | 1 | Level-3 enable for fine-grained trapping |
| fgt_rd_n | input | 1 | Fine-grained read trap, active low |
| fgt_wr_n | input | 1 | Fine-grained write trap, active low |
| nv_mode | input | 3 | Nested-virtualisation mode bits |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 3 | Outcome code |
| rsp_class | output | 6 | Exception class for traps |
| rsp_rdata | output | 64 | Read data for completed reads |
| mem_req_valid | output | 1 | Redirected memory request |
| mem_req_write | output | 1 | Direction of redirected request |
| mem_req_addr | output | 12 | Memory offset of redirected request |
| mem_req_wdata | output | 64 | Write data of redirected request |
| perm_value | output | 64 | Current register contents |

## Verification
The assertions assume that `req_level` is a clean two-bit value and that the control inputs hold steady while a request is sampled. They also assume that reset is applied for at least one edge before the first request. The stimulus drives every input only on the falling edge and asserts reset for several cycles before the sweep. In each request the direction-dependent control bits are set to opposite values for the unused direction, so that a check that reads the wrong direction cannot go unseen.

// File: rtl/perm_ovl_pkg.sv
package perm_ovl_pkg;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = 16;
  localparam int REG_W      = FIELD_W * NUM_FIELDS;
  localparam int ADDR_W     = 12;
  localparam int CLASS_W    = 6;
  localparam logic [ADDR_W-1:0]  REDIR_ADDR = 12'h2B8;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

  typedef enum logic [2:0] {
    OUT_DONE   = 3'd0,
    OUT_UNDEF  = 3'd1,
    OUT_TRAP2  = 3'd2,
    OUT_TRAP3  = 3'd3,
    OUT_REDIR  = 3'd4
  } outcome_e;
endpackage

// File: rtl/pov_decide.sv
module pov_decide
  import perm_ovl_pkg::*;
(
  input  logic       is_write,
  input  logic [1:0] level,
  input  logic       el3_present,
  input  logic       el2_enabled,
  input  logic       undef_prio,
  input  logic       undef_sel,
  input  logic       feat_en,
  input  logic       trap_rd,
  input  logic       trap_wr,
  input  logic       fgt_present,
  input  logic       fgt_el3_en,
  input  logic       fgt_rd_n,
  input  logic       fgt_wr_n,
  input  logic [2:0] nv_mode,
  output outcome_e   outcome
);
  logic gate_undef;
  logic coarse_hit;
  logic fine_hit;
  logic feat_block;
  logic nv_redirect;

  always_comb begin
    gate_undef  = el3_present && undef_prio && !feat_en;
    coarse_hit  = el2_enabled && (is_write ? trap_wr : trap_rd);
    fine_hit    = el2_enabled && fgt_present && (!el3_present || fgt_el3_en)
                  && !(is_write ? fgt_wr_n : fgt_rd_n);
    feat_block  = el3_present && !feat_en;
    nv_redirect = nv_mode[2] && nv_mode[0];
  end

  always_comb begin
    outcome = OUT_DONE;
    unique case (level)
      2'd0: outcome = OUT_UNDEF;
      2'd1: begin
        if (gate_undef)       outcome = OUT_UNDEF;
        else if (coarse_hit)  outcome = OUT_TRAP2;
        else if (fine_hit)    outcome = OUT_TRAP2;
        else if (feat_block)  outcome = undef_sel ? OUT_UNDEF : OUT_TRAP3;
        else if (nv_redirect) outcome = OUT_REDIR;
        else                  outcome = OUT_DONE;
      end
      2'd2: begin
        if (gate_undef)       outcome = OUT_UNDEF;
        else if (feat_block)  outcome = undef_sel ? OUT_UNDEF : OUT_TRAP3;
        else                  outcome = OUT_DONE;
      end
      default: outcome = OUT_DONE;
    endcase
  end
endmodule

// File: rtl/pov_store.sv
module pov_store #(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 16,
  localparam int REG_W     = FIELD_W * NUM_FIELDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] value
);
  for (genvar m = 0; m < NUM_FIELDS; m++) begin : g_field
    logic [FIELD_W-1:0] field_q;
    always_ff @(posedge clk) begin
      if (rst)        field_q <= '0;
      else if (wr_en) field_q <= wr_data[m*FIELD_W +: FIELD_W];
    end
    assign value[m*FIELD_W +: FIELD_W] = field_q;
  end
endmodule

// File: rtl/pov_resp_stage.sv
module pov_resp_stage
  import perm_ovl_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_write,
  input  outcome_e           in_outcome,
  input  logic [DATA_W-1:0]  in_wdata,
  input  logic [DATA_W-1:0]  in_regval,
  output logic               rsp_valid,
  output logic [2:0]         rsp_kind,
  output logic [CLASS_W-1:0] rsp_class,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               mem_valid,
  output logic               mem_write,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata
);
  logic is_trap;
  logic is_redir;
  assign is_trap  = (in_outcome == OUT_TRAP2) || (in_outcome == OUT_TRAP3);
  assign is_redir = (in_outcome == OUT_REDIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_class <= '0;
      rsp_rdata <= '0;
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= in_valid;
      rsp_kind  <= in_valid ? in_outcome : OUT_DONE;
      rsp_class <= (in_valid && is_trap) ? TRAP_CLASS : '0;
      rsp_rdata <= (in_valid && in_outcome == OUT_DONE && !in_write) ? in_regval : '0;
      mem_valid <= in_valid && is_redir;
      mem_write <= in_valid && is_redir && in_write;
      mem_addr  <= (in_valid && is_redir) ? REDIR_ADDR : '0;
      mem_wdata <= (in_valid && is_redir && in_write) ? in_wdata : '0;
    end
  end
endmodule

// File: rtl/perm_overlay_access_ctrl.sv
module perm_overlay_access_ctrl
  import perm_ovl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_level,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic               el3_present,
  input  logic               el2_enabled,
  input  logic               undef_prio,
  input  logic               undef_sel,
  input  logic               feat_en,
  input  logic               trap_rd,
  input  logic               trap_wr,
  input  logic               fgt_present,
  input  logic               fgt_el3_en,
  input  logic               fgt_rd_n,
  input  logic               fgt_wr_n,
  input  logic [2:0]         nv_mode,
  output logic               rsp_valid,
  output logic [2:0]         rsp_kind,
  output logic [CLASS_W-1:0] rsp_class,
  output logic [REG_W-1:0]   rsp_rdata,
  output logic               mem_req_valid,
  output logic               mem_req_write,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [REG_W-1:0]   mem_req_wdata,
  output logic [REG_W-1:0]   perm_value
);
  outcome_e decision;
  logic     store_we;

  pov_decide u_decide (
    .is_write    (req_write),
    .level       (req_level),
    .el3_present (el3_present),
    .el2_enabled (el2_enabled),
    .undef_prio  (undef_prio),
    .undef_sel   (undef_sel),
    .feat_en     (feat_en),
    .trap_rd     (trap_rd),
    .trap_wr     (trap_wr),
    .fgt_present (fgt_present),
    .fgt_el3_en  (fgt_el3_en),
    .fgt_rd_n    (fgt_rd_n),
    .fgt_wr_n    (fgt_wr_n),
    .nv_mode     (nv_mode),
    .outcome     (decision)
  );

  assign store_we = req_valid && req_write && (decision == OUT_DONE);

  pov_store #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (store_we),
    .wr_data (req_wdata),
    .value   (perm_value)
  );

  pov_resp_stage #(.DATA_W(REG_W)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (req_valid),
    .in_write   (req_write),
    .in_outcome (decision),
    .in_wdata   (req_wdata),
    .in_regval  (perm_value),
    .rsp_valid  (rsp_valid),
    .rsp_kind   (rsp_kind),
    .rsp_class  (rsp_class),
    .rsp_rdata  (rsp_rdata),
    .mem_valid  (mem_req_valid),
    .mem_write  (mem_req_write),
    .mem_addr   (mem_req_addr),
    .mem_wdata  (mem_req_wdata)
  );
endmodule

// File: rtl/pov_checker.sv
module pov_checker
  import perm_ovl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [1:0]         req_level,
  input logic               rsp_valid,
  input logic [2:0]         rsp_kind,
  input logic [CLASS_W-1:0] rsp_class,
  input logic               mem_req_valid,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic [REG_W-1:0]   perm_value
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (perm_value == '0 && !rsp_valid && !mem_req_valid));

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_level0_undef_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_level == 2'd0) |=> (rsp_kind == 3'd1));

  assert_redirect_port_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 3'd4) |-> (mem_req_valid && mem_req_addr == 12'h2B8));

  assert_level3_done_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_level == 2'd3) |=> (rsp_kind == 3'd0));

  assert_trap_class_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_kind == 3'd2 || rsp_kind == 3'd3)) |-> (rsp_class == 6'h18));

  assert_reg_change_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(perm_value) |-> (rsp_valid && rsp_kind == 3'd0));
endmodule

bind perm_overlay_access_ctrl pov_checker u_pov_checker (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_level     (req_level),
  .rsp_valid     (rsp_valid),
  .rsp_kind      (rsp_kind),
  .rsp_class     (rsp_class),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .perm_value    (perm_value)
);

// File: tb/tb_perm_overlay_access_ctrl.sv
module tb_perm_overlay_access_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 60000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_level = '0;
  logic [63:0] req_wdata = '0;
  logic el3_present = 0, el2_enabled = 0, undef_prio = 0, undef_sel = 0, feat_en = 0;
  logic trap_rd = 0, trap_wr = 0, fgt_present = 0, fgt_el3_en = 0, fgt_rd_n = 0, fgt_wr_n = 0;
  logic [2:0]  nv_mode = '0;
  logic        rsp_valid, mem_req_valid, mem_req_write;
  logic [2:0]  rsp_kind;
  logic [5:0]  rsp_class;
  logic [63:0] rsp_rdata, mem_req_wdata, perm_value;
  logic [11:0] mem_req_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_overlay_access_ctrl dut (.*);

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model_kind(input logic [1:0] lv, input logic wr,
      input logic e3, input logic e2, input logic pr, input logic sl, input logic fe,
      input logic vm, input logic fp, input logic fx, input logic fn, input logic [2:0] nv);
    if (lv == 0) return 3'd1;
    if (lv == 3) return 3'd0;
    if (e3 && pr && !fe) return 3'd1;
    if (lv == 1 && e2 && vm) return 3'd2;
    if (lv == 1 && e2 && fp && (!e3 || fx) && !fn) return 3'd2;
    if (e3 && !fe) return sl ? 3'd1 : 3'd3;
    if (lv == 1 && nv[2] && nv[0]) return 3'd4;
    return 3'd0;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] model_reg;
    model_reg = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check64("R1 perm_value after reset", perm_value, 64'h0);
    check64("R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    check64("R1 mem_req_valid after reset", {63'h0, mem_req_valid}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check64("R2 no response while idle", {63'h0, rsp_valid}, 64'h0);

    for (int i = 0; i < 32768; i++) begin
      logic [14:0] v;
      logic [2:0]  ek;
      logic [63:0] prev;
      logic vm, fn;
      v  = 15'(i);
      vm = v[8];
      fn = v[11];
      req_valid   = 1'b1;
      req_level   = v[1:0];
      req_write   = v[2];
      el3_present = v[3];
      el2_enabled = v[4];
      undef_prio  = v[5];
      undef_sel   = v[6];
      feat_en     = v[7];
      trap_wr     = v[2] ? vm : ~vm;
      trap_rd     = v[2] ? ~vm : vm;
      fgt_present = v[9];
      fgt_el3_en  = v[10];
      fgt_wr_n    = v[2] ? fn : ~fn;
      fgt_rd_n    = v[2] ? ~fn : fn;
      nv_mode     = v[14:12];
      req_wdata   = {32'(i) * 32'h9E37_79B1, 32'(i) ^ 32'hA5A5_5A5A};
      ek   = model_kind(v[1:0], v[2], v[3], v[4], v[5], v[6], v[7], vm, v[9], v[10], fn, v[14:12]);
      prev = model_reg;
      if (ek == 3'd0 && v[2]) model_reg = req_wdata;
      @(negedge clk);
      check64("R2 rsp_valid", {63'h0, rsp_valid}, 64'h1);
      // R3 R4 R5 R6 R7 R8 R9: outcome priority chain
      check64($sformatf("R3-R9 kind idx=%0d lvl=%0d", i, v[1:0]), {61'h0, rsp_kind}, {61'h0, ek});
      check64("R10 class", {58'h0, rsp_class},
              (ek == 3'd2 || ek == 3'd3) ? 64'h18 : 64'h0);
      check64("R8 mem_req_valid", {63'h0, mem_req_valid}, {63'h0, ek == 3'd4});
      check64("R8 mem_req_addr", {52'h0, mem_req_addr}, (ek == 3'd4) ? 64'h2B8 : 64'h0);
      check64("R8 mem_req_write", {63'h0, mem_req_write}, {63'h0, ek == 3'd4 && v[2]});
      check64("R8 mem_req_wdata", mem_req_wdata, (ek == 3'd4 && v[2]) ? req_wdata : 64'h0);
      check64("R11 perm_value", perm_value, model_reg);
      check64("R12 rsp_rdata", rsp_rdata, (ek == 3'd0 && !v[2]) ? prev : 64'h0);
    end

    // R11: field placement after a level-3 write, then read back (R12)
    req_level = 2'd3; req_write = 1'b1; req_wdata = 64'hFEDC_BA98_7654_3210;
    @(negedge clk);
    for (int m = 0; m < 16; m++)
      check64($sformatf("R11 field %0d", m), {60'h0, perm_value[4*m +: 4]}, 64'(m));
    req_write = 1'b0;
    @(negedge clk);
    check64("R12 read after write", rsp_rdata, 64'hFEDC_BA98_7654_3210);

    // R1: reset clears a written register
    req_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check64("R1 reset clears register", perm_value, 64'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule